// File: doc/BRIEF.md
# Host Memory Window Translator

This block sits behind a host register space and turns word accesses aimed at three fixed host apertures into requests on a wider card-memory address space. Each aperture has a fixed host base and a largest size. It also has two programmable registers. The first is a size code that can shrink the decoded span. The second is a position register that says where in card memory the aperture currently points. A host access that lands inside an aperture goes out as one card-memory request. Its address is the window position plus the distance of the host address above the aperture base.

A mode pin selects between two generations. In the narrow generation, positions are kept at 16-byte granularity and the third aperture is 64 KB at host 0x30000. In the wide generation, positions are kept at 128-byte granularity, the third aperture is 128 KB at host 0x60000, and a physical-function tag is stored with the position and sent out with every request. The mode pin is treated as static and may change only while reset is asserted.

The host request, the host response and the card request are valid/ready channels. A payload is presented with valid and must stay unchanged until ready is seen high on a rising edge. The block handles one access at a time. It raises host ready only when it is idle. It holds the card request until the card accepts it and holds the response until the host takes it. Card read data comes back on a plain strobe with no back-pressure.

Top module: `memwin_xlate`

## Requirements
- R1: Window 0 decodes host addresses 0x1B800 to 0x1BFFF (2 KB) and window 1 decodes 0x28000 to 0x2FFFF (32 KB). At most one window claims any address.
- R2: Window 2 decodes 0x30000 to 0x3FFFF when wide_mode is 0, and 0x60000 to 0x7FFFF when wide_mode is 1. The other range of that pair is unmapped in each mode.
- R3: A size write (cfg_field=0) stores cfg_wdata[3:0] as log2(span in bytes) minus 10. Values above the window's largest code are clamped to it. Reset loads the largest code: 1, 5, and 6 (narrow) or 7 (wide). Addresses above the programmed span are unmapped.
- R4: A position write (cfg_field=1) clears bits [3:0] in narrow mode and bits [6:0] in wide mode. Reading the position returns the aligned position ORed with the stored tag.
- R5: In wide mode, the tag is cfg_wdata[2:0] of the position write and is driven on c_pf with each request of that window. In narrow mode, the stored tag is zero.
- R6: The card address is the window position plus the host address minus the window base.
- R7: A host address with nonzero bits [1:0] is answered with rsp_err=1 and rsp_data=0, and no card request is made.
- R8: A host address outside every decoded span is answered with rsp_err=1 and rsp_data=0, and no card request is made.
- R9: A configuration write on one rising edge governs a host access accepted on the next rising edge.
- R10: Card read data is returned to rsp_data unchanged. Host write data is sent on c_wdata unchanged. A forwarded write is answered with rsp_err=0 and rsp_data=0.
- R11: Only one access is in flight at a time. c_valid with its payload and rsp_valid with its payload hold steady until the matching ready is high.
- R12: After reset, all positions and tags are zero, h_ready=1, c_valid=0 and rsp_valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wide_mode | input | 1 | 0 selects the narrow generation, 1 the wide generation; static outside reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_win | input | 2 | Window index for configuration write and readback (3 selects nothing) |
| cfg_field | input | 1 | 0 selects the size code, 1 selects the position register |
| cfg_wdata | input | CAW | Configuration write data |
| cfg_rdata | output | CAW | Readback of the selected field of the selected window |
| h_valid | input | 1 | Host request valid |
| h_ready | output | 1 | Host request ready (high when idle) |
| h_write | input | 1 | Host request is a write |
| h_addr | input | HAW | Host byte address |
| h_wdata | input | DW | Host write data |
| rsp_valid | output | 1 | Host response valid |
| rsp_ready | input | 1 | Host response ready |
| rsp_data | output | DW | Read data, zero for writes and errors |
| rsp_err | output | 1 | Misaligned or unmapped access |
| c_valid | output | 1 | Card request valid |
| c_ready | input | 1 | Card request ready |
| c_write | output | 1 | Card request is a write |
| c_addr | output | CAW | Translated card byte address |
| c_pf | output | PFW | Function tag of the window |
| c_wdata | output | DW | Card write data |
| c_rvalid | input | 1 | Card read data strobe |
| c_rdata | input | DW | Card read data |

## Verification
The bench probes the first and last word of every aperture and the words just outside them. A decoder with a wrong bound either forwards a stray access or rejects a valid one. It shrinks and then over-programs a size code, so a missing clamp or a wrong log2 encoding shows up as a wrong edge. Position writes use low bits that both alignment masks would strip differently. This exposes a design that aligns at the wrong granularity, or that keeps a tag in narrow mode. A misaligned word inside an aperture, a position rewrite followed at once by an access, and stalls on both ready inputs check that errors are not forwarded and that stale decode state is not used. They also check that held payloads do not drift.

// File: rtl/memwin_pkg.sv
package memwin_pkg;

  localparam int NWIN  = 3;
  localparam int WINW  = 2;
  localparam int SZW   = 4;
  localparam int SZ_LO = 10;
  localparam int ALN_N = 4;
  localparam int ALN_W = 7;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_RESP  = 2'd3
  } xl_state_t;

  // Host base of each aperture; window 2 moves with the generation.
  function automatic logic [31:0] win_base(input int idx, input logic wide);
    case (idx)
      0:       return 32'h0001_B800;
      1:       return 32'h0002_8000;
      default: return wide ? 32'h0006_0000 : 32'h0003_0000;
    endcase
  endfunction

  // Largest size code, log2(bytes) - SZ_LO.
  function automatic logic [SZW-1:0] win_maxsz(input int idx, input logic wide);
    case (idx)
      0:       return SZW'(1);
      1:       return SZW'(5);
      default: return wide ? SZW'(7) : SZW'(6);
    endcase
  endfunction

endpackage

// File: rtl/memwin_regs.sv
module memwin_regs
  import memwin_pkg::*;
#(
  parameter int CAW = 32,
  parameter int PFW = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wide_mode,
  input  logic                       cfg_we,
  input  logic [WINW-1:0]            cfg_win,
  input  logic                       cfg_field,
  input  logic [CAW-1:0]             cfg_wdata,
  output logic [CAW-1:0]             cfg_rdata,
  output logic [NWIN-1:0][CAW-1:0]   pos_o,
  output logic [NWIN-1:0][PFW-1:0]   pf_o,
  output logic [NWIN-1:0][SZW-1:0]   sz_o
);

  logic [CAW-1:0] align_mask;
  assign align_mask = wide_mode ? {{(CAW-ALN_W){1'b1}}, {ALN_W{1'b0}}}
                                : {{(CAW-ALN_N){1'b1}}, {ALN_N{1'b0}}};

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    logic [CAW-1:0] pos_q;
    logic [PFW-1:0] pf_q;
    logic [SZW-1:0] shrink_q;
    logic [SZW-1:0] maxsz;
    logic           sel;

    assign maxsz = win_maxsz(w, wide_mode);
    assign sel   = cfg_we && (cfg_win == WINW'(w));

    // The size is kept as a distance below the largest code, so reset is constant.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pos_q    <= '0;
        pf_q     <= '0;
        shrink_q <= '0;
      end else if (sel) begin
        if (cfg_field) begin
          pos_q <= cfg_wdata & align_mask;
          pf_q  <= wide_mode ? cfg_wdata[PFW-1:0] : '0;
        end else begin
          shrink_q <= (cfg_wdata[SZW-1:0] >= maxsz) ? '0 : (maxsz - cfg_wdata[SZW-1:0]);
        end
      end
    end

    assign pos_o[w] = pos_q;
    assign pf_o[w]  = pf_q;
    assign sz_o[w]  = maxsz - shrink_q;

    AST_POS_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      pos_q[ALN_N-1:0] == '0); // R4
    AST_PF_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && cfg_field && !wide_mode) |=> (pf_q == '0)); // R5
    AST_SZ_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && !cfg_field) |=> (sz_o[w] <= maxsz)); // R3
  end

  always_comb begin
    cfg_rdata = '0;
    for (int w = 0; w < NWIN; w++) begin
      if (cfg_win == WINW'(w)) begin
        cfg_rdata = cfg_field ? (pos_o[w] | CAW'(pf_o[w])) : CAW'(sz_o[w]);
      end
    end
  end

endmodule

// File: rtl/memwin_decode.sv
module memwin_decode
  import memwin_pkg::*;
#(
  parameter int HAW = 20,
  parameter int CAW = 32,
  parameter int PFW = 3
) (
  input  logic                       wide_mode,
  input  logic [HAW-1:0]             h_addr,
  input  logic [NWIN-1:0][CAW-1:0]   pos_i,
  input  logic [NWIN-1:0][PFW-1:0]   pf_i,
  input  logic [NWIN-1:0][SZW-1:0]   sz_i,
  output logic [NWIN-1:0]            hit_o,
  output logic                       err_o,
  output logic [CAW-1:0]             addr_o,
  output logic [PFW-1:0]             pf_o
);

  localparam int XW = HAW + 1;

  logic [NWIN-1:0][CAW-1:0] xl;

  for (genvar w = 0; w < NWIN; w++) begin : g_dec
    logic [XW-1:0] base;
    logic [XW-1:0] off;
    logic [XW-1:0] span;

    assign base     = XW'(win_base(w, wide_mode));
    assign off      = {1'b0, h_addr} - base;
    assign span     = XW'(1) << (32'(sz_i[w]) + SZ_LO);
    assign hit_o[w] = ({1'b0, h_addr} >= base) && (off < span);
    assign xl[w]    = pos_i[w] + CAW'(off);
  end

  always_comb begin
    addr_o = '0;
    pf_o   = '0;
    for (int w = NWIN - 1; w >= 0; w--) begin
      if (hit_o[w]) begin
        addr_o = xl[w];
        pf_o   = pf_i[w];
      end
    end
  end

  assign err_o = (h_addr[1:0] != 2'b00) || (hit_o == '0);

endmodule

// File: rtl/memwin_ctrl.sv
module memwin_ctrl
  import memwin_pkg::*;
#(
  parameter int CAW = 32,
  parameter int DW  = 32,
  parameter int PFW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           h_valid,
  output logic           h_ready,
  input  logic           h_write,
  input  logic [DW-1:0]  h_wdata,
  input  logic           dec_err,
  input  logic [CAW-1:0] dec_addr,
  input  logic [PFW-1:0] dec_pf,
  output logic           rsp_valid,
  input  logic           rsp_ready,
  output logic [DW-1:0]  rsp_data,
  output logic           rsp_err,
  output logic           c_valid,
  input  logic           c_ready,
  output logic           c_write,
  output logic [CAW-1:0] c_addr,
  output logic [PFW-1:0] c_pf,
  output logic [DW-1:0]  c_wdata,
  input  logic           c_rvalid,
  input  logic [DW-1:0]  c_rdata
);

  xl_state_t      st_q;
  logic           wr_q;
  logic           err_q;
  logic [CAW-1:0] addr_q;
  logic [PFW-1:0] pf_q;
  logic [DW-1:0]  wdata_q;
  logic [DW-1:0]  rdata_q;
  logic           acc;

  assign h_ready = (st_q == ST_IDLE);
  assign acc     = h_valid && h_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      wr_q    <= 1'b0;
      err_q   <= 1'b0;
      addr_q  <= '0;
      pf_q    <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (acc) begin
          wr_q    <= h_write;
          err_q   <= dec_err;
          addr_q  <= dec_addr;
          pf_q    <= dec_pf;
          wdata_q <= h_wdata;
          rdata_q <= '0;
          st_q    <= dec_err ? ST_RESP : ST_ISSUE;
        end
        ST_ISSUE: if (c_ready) st_q <= wr_q ? ST_RESP : ST_WAIT;
        ST_WAIT: if (c_rvalid) begin
          rdata_q <= c_rdata;
          st_q    <= ST_RESP;
        end
        default: if (rsp_ready) st_q <= ST_IDLE;
      endcase
    end
  end

  assign c_valid   = (st_q == ST_ISSUE);
  assign c_write   = wr_q;
  assign c_addr    = addr_q;
  assign c_pf      = pf_q;
  assign c_wdata   = wdata_q;
  assign rsp_valid = (st_q == ST_RESP);
  assign rsp_data  = rdata_q;
  assign rsp_err   = err_q;

  AST_CREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (c_valid && !c_ready) |=> (c_valid && $stable(c_addr) && $stable(c_wdata) && $stable(c_write))); // R11
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_err))); // R11
  AST_ERR_NOFWD: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && dec_err) |=> (rsp_valid && rsp_err && !c_valid)); // R7
  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_data == '0)); // R8
  AST_WR_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (c_valid && c_ready && c_write) |=> (rsp_valid && !rsp_err && rsp_data == '0)); // R10

endmodule

// File: rtl/memwin_xlate.sv
module memwin_xlate
  import memwin_pkg::*;
#(
  parameter int HAW = 20,
  parameter int CAW = 32,
  parameter int DW  = 32,
  parameter int PFW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wide_mode,
  input  logic            cfg_we,
  input  logic [WINW-1:0] cfg_win,
  input  logic            cfg_field,
  input  logic [CAW-1:0]  cfg_wdata,
  output logic [CAW-1:0]  cfg_rdata,
  input  logic            h_valid,
  output logic            h_ready,
  input  logic            h_write,
  input  logic [HAW-1:0]  h_addr,
  input  logic [DW-1:0]   h_wdata,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [DW-1:0]   rsp_data,
  output logic            rsp_err,
  output logic            c_valid,
  input  logic            c_ready,
  output logic            c_write,
  output logic [CAW-1:0]  c_addr,
  output logic [PFW-1:0]  c_pf,
  output logic [DW-1:0]   c_wdata,
  input  logic            c_rvalid,
  input  logic [DW-1:0]   c_rdata
);

  logic [NWIN-1:0][CAW-1:0] pos;
  logic [NWIN-1:0][PFW-1:0] pf;
  logic [NWIN-1:0][SZW-1:0] sz;
  logic [NWIN-1:0]          hit;
  logic                     dec_err;
  logic [CAW-1:0]           dec_addr;
  logic [PFW-1:0]           dec_pf;

  memwin_regs #(.CAW(CAW), .PFW(PFW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wide_mode (wide_mode),
    .cfg_we    (cfg_we),
    .cfg_win   (cfg_win),
    .cfg_field (cfg_field),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .pos_o     (pos),
    .pf_o      (pf),
    .sz_o      (sz)
  );

  memwin_decode #(.HAW(HAW), .CAW(CAW), .PFW(PFW)) u_dec (
    .wide_mode (wide_mode),
    .h_addr    (h_addr),
    .pos_i     (pos),
    .pf_i      (pf),
    .sz_i      (sz),
    .hit_o     (hit),
    .err_o     (dec_err),
    .addr_o    (dec_addr),
    .pf_o      (dec_pf)
  );

  memwin_ctrl #(.CAW(CAW), .DW(DW), .PFW(PFW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .h_valid   (h_valid),
    .h_ready   (h_ready),
    .h_write   (h_write),
    .h_wdata   (h_wdata),
    .dec_err   (dec_err),
    .dec_addr  (dec_addr),
    .dec_pf    (dec_pf),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_data  (rsp_data),
    .rsp_err   (rsp_err),
    .c_valid   (c_valid),
    .c_ready   (c_ready),
    .c_write   (c_write),
    .c_addr    (c_addr),
    .c_pf      (c_pf),
    .c_wdata   (c_wdata),
    .c_rvalid  (c_rvalid),
    .c_rdata   (c_rdata)
  );

  AST_ONE_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit)); // R1
  AST_BUSY_NOACC: assert property (@(posedge clk) disable iff (!rst_n)
    (c_valid || rsp_valid) |-> !h_ready); // R11

endmodule

// File: tb/sim_memwin_xlate.sv
module sim_memwin_xlate;

  localparam logic [31:0] MAGIC = 32'h5A5A_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wide_mode = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_win = 2'd0;
  logic        cfg_field = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        h_valid = 1'b0;
  logic        h_ready;
  logic        h_write = 1'b0;
  logic [19:0] h_addr = '0;
  logic [31:0] h_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_data;
  logic        rsp_err;
  logic        c_valid;
  logic        c_ready = 1'b1;
  logic        c_write;
  logic [31:0] c_addr;
  logic [2:0]  c_pf;
  logic [31:0] c_wdata;
  logic        c_rvalid = 1'b0;
  logic [31:0] c_rdata = '0;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  memwin_xlate u0 (
    .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode),
    .cfg_we(cfg_we), .cfg_win(cfg_win), .cfg_field(cfg_field),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .h_valid(h_valid), .h_ready(h_ready), .h_write(h_write),
    .h_addr(h_addr), .h_wdata(h_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_err(rsp_err),
    .c_valid(c_valid), .c_ready(c_ready), .c_write(c_write), .c_addr(c_addr),
    .c_pf(c_pf), .c_wdata(c_wdata), .c_rvalid(c_rvalid), .c_rdata(c_rdata)
  );

  typedef struct packed {
    logic        wr;
    logic [19:0] a;
    logic [31:0] wd;
    logic        fwd;
    logic [31:0] ca;
    logic [7:0]  tag;
  } vec_t;

  // Narrow mode, positions 0x12340 / 0x400000 / 0x10000000, full sizes.
  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 20'h1B800, 32'h0,         1'b1, 32'h0001_2340, 8'd1},
    '{1'b0, 20'h1BFFC, 32'h0,         1'b1, 32'h0001_2B3C, 8'd1},
    '{1'b0, 20'h1C000, 32'h0,         1'b0, 32'h0,         8'd8},
    '{1'b1, 20'h28010, 32'hDEAD_BEEF, 1'b1, 32'h0040_0010, 8'd10},
    '{1'b0, 20'h2FFFC, 32'h0,         1'b1, 32'h0040_7FFC, 8'd6},
    '{1'b0, 20'h30000, 32'h0,         1'b1, 32'h1000_0000, 8'd2},
    '{1'b0, 20'h3FFFC, 32'h0,         1'b1, 32'h1000_FFFC, 8'd2},
    '{1'b0, 20'h40000, 32'h0,         1'b0, 32'h0,         8'd2},
    '{1'b0, 20'h1B802, 32'h0,         1'b0, 32'h0,         8'd7},
    '{1'b0, 20'h60000, 32'h0,         1'b0, 32'h0,         8'd2},
    '{1'b0, 20'h1B7FC, 32'h0,         1'b0, 32'h0,         8'd1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfgw(input logic [1:0] win, input logic fld, input logic [31:0] d);
    cfg_we = 1'b1; cfg_win = win; cfg_field = fld; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rdback(input logic [1:0] win, input logic fld, output logic [31:0] d);
    cfg_win = win; cfg_field = fld;
    #1;
    d = cfg_rdata;
  endtask

  // Starts at a falling edge; returns at a falling edge after the response.
  task automatic access(input logic wr, input logic [19:0] a, input logic [31:0] wd,
                        input int bp, output logic fwd, output logic [31:0] ca,
                        output logic [2:0] cpf, output logic cwr, output logic [31:0] cwd,
                        output logic [31:0] rd, output logic er, output logic dn);
    logic        pend;
    logic [31:0] cap;
    logic        acc_now;
    int          stall;
    fwd = 0; ca = '0; cpf = '0; cwr = 0; cwd = '0; rd = '0; er = 0; dn = 0;
    pend = 0; cap = '0; stall = bp;
    h_valid = 1'b1; h_write = wr; h_addr = a; h_wdata = wd;
    for (int k = 0; k < 60 && !dn; k++) begin
      c_rvalid = 1'b0;
      if (pend) begin
        c_rvalid = 1'b1; c_rdata = cap ^ MAGIC; pend = 0;
      end
      c_ready = (stall == 0);
      rsp_ready = (stall == 0);
      if (stall > 0 && (c_valid || rsp_valid)) stall--;
      acc_now = h_valid && h_ready;
      if (c_valid && c_ready) begin
        fwd = 1; ca = c_addr; cpf = c_pf; cwr = c_write; cwd = c_wdata;
        if (!c_write) begin pend = 1; cap = c_addr; end
      end
      if (rsp_valid && rsp_ready) begin
        rd = rsp_data; er = rsp_err; dn = 1;
      end
      @(negedge clk);
      c_rvalid = 1'b0;
      if (acc_now) h_valid = 1'b0;
    end
    h_valid = 1'b0;
    c_ready = 1'b1;
    rsp_ready = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL R11 watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic        fwd, cwr, er, dn;
    logic [31:0] ca, cwd, rd, d;
    logic [2:0]  cpf;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R12 reset state
    chk("R12 h_ready", 32'(h_ready), 32'd1);
    chk("R12 c_valid", 32'(c_valid), 32'd0);
    chk("R12 rsp_valid", 32'(rsp_valid), 32'd0);
    rdback(2'd0, 1'b1, d); chk("R12 pos0 reset", d, 32'h0);
    rdback(2'd0, 1'b0, d); chk("R3 size0 reset", d, 32'd1);
    rdback(2'd1, 1'b0, d); chk("R3 size1 reset", d, 32'd5);
    rdback(2'd2, 1'b0, d); chk("R3 size2 narrow reset", d, 32'd6);

    @(negedge clk);
    cfgw(2'd0, 1'b1, 32'h0001_2345);
    cfgw(2'd1, 1'b1, 32'h0040_0008);
    cfgw(2'd2, 1'b1, 32'h1000_000F);
    rdback(2'd0, 1'b1, d); chk("R4 narrow align win0", d, 32'h0001_2340);
    rdback(2'd2, 1'b1, d); chk("R4 R5 narrow align win2 no tag", d, 32'h1000_0000);
    @(negedge clk);

    // Table walk: R1 R2 R6 R7 R8 R10 R11
    for (int i = 0; i < NV; i++) begin
      access(VECS[i].wr, VECS[i].a, VECS[i].wd, i % 3, fwd, ca, cpf, cwr, cwd, rd, er, dn);
      chk($sformatf("R11 done vec%0d", i), 32'(dn), 32'd1);
      chk($sformatf("R%0d forward vec%0d", VECS[i].tag, i), 32'(fwd), 32'(VECS[i].fwd));
      chk($sformatf("R%0d err vec%0d", VECS[i].tag, i), 32'(er), 32'(!VECS[i].fwd));
      if (VECS[i].fwd) begin
        chk($sformatf("R6 card addr vec%0d", i), ca, VECS[i].ca);
        chk($sformatf("R5 narrow tag vec%0d", i), 32'(cpf), 32'd0);
        chk($sformatf("R10 write flag vec%0d", i), 32'(cwr), 32'(VECS[i].wr));
        if (VECS[i].wr) begin
          chk($sformatf("R10 wdata vec%0d", i), cwd, VECS[i].wd);
          chk($sformatf("R10 write rsp data vec%0d", i), rd, 32'h0);
        end else begin
          chk($sformatf("R10 rdata vec%0d", i), rd, VECS[i].ca ^ MAGIC);
        end
      end else begin
        chk($sformatf("R7 R8 err data vec%0d", i), rd, 32'h0);
      end
    end

    // R3 shrink window 1 to 4 KB
    cfgw(2'd1, 1'b0, 32'h0000_0002);
    rdback(2'd1, 1'b0, d); chk("R3 size1 shrunk", d, 32'd2);
    @(negedge clk);
    access(1'b0, 20'h28FFC, 32'h0, 0, fwd, ca, cpf, cwr, cwd, rd, er, dn);
    chk("R3 last word of shrunk span", ca, 32'h0040_0FFC);
    access(1'b0, 20'h29000, 32'h0, 1, fwd, ca, cpf, cwr, cwd, rd, er, dn);
    chk("R3 beyond shrunk span err", 32'(er), 32'd1);
    chk("R3 beyond shrunk span not forwarded", 32'(fwd), 32'd0);
    // R3 clamp
    cfgw(2'd1, 1'b0, 32'h0000_000F);
    rdback(2'd1, 1'b0, d); chk("R3 size1 clamped", d, 32'd5);
    @(negedge clk);
    access(1'b0, 20'h29000, 32'h0, 0, fwd, ca, cpf, cwr, cwd, rd, er, dn);
    chk("R3 restored span", ca, 32'h0040_1000);

    // R9 rewrite then immediate access
    cfgw(2'd0, 1'b1, 32'h00AB_C000);
    access(1'b0, 20'h1B804, 32'h0, 0, fwd, ca, cpf, cwr, cwd, rd, er, dn);
    chk("R9 new position used", ca, 32'h00AB_C004);
    chk("R10 rdata after R9", rd, 32'h00AB_C004 ^ MAGIC);

    // Wide generation
    rst_n = 1'b0; wide_mode = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    rdback(2'd2, 1'b0, d); chk("R3 size2 wide reset", d, 32'd7);
    rdback(2'd1, 1'b1, d); chk("R12 pos1 after reset", d, 32'h0);
    @(negedge clk);
    cfgw(2'd2, 1'b1, 32'h2000_00FB);
    cfgw(2'd0, 1'b1, 32'h0001_2345);
    rdback(2'd2, 1'b1, d); chk("R4 R5 wide align win2 with tag", d, 32'h2000_0083);
    rdback(2'd0, 1'b1, d); chk("R4 R5 wide align win0 with tag", d, 32'h0001_2305);
    @(negedge clk);
    access(1'b0, 20'h60104, 32'h0, 2, fwd, ca, cpf, cwr, cwd, rd, er, dn);
    chk("R2 R6 wide win2 addr", ca, 32'h2000_0184);
    chk("R5 wide win2 tag", 32'(cpf), 32'd3);
    chk("R10 wide rdata", rd, 32'h2000_0184 ^ MAGIC);
    access(1'b1, 20'h7FFFC, 32'h1234_5678, 1, fwd, ca, cpf, cwr, cwd, rd, er, dn);
    chk("R2 wide win2 last word", ca, 32'h2002_007C);
    chk("R10 wide wdata", cwd, 32'h1234_5678);
    access(1'b0, 20'h30000, 32'h0, 0, fwd, ca, cpf, cwr, cwd, rd, er, dn);
    chk("R2 narrow range unmapped in wide err", 32'(er), 32'd1);
    chk("R2 narrow range unmapped in wide fwd", 32'(fwd), 32'd0);
    access(1'b0, 20'h1B800, 32'h0, 0, fwd, ca, cpf, cwr, cwd, rd, er, dn);
    chk("R1 R5 wide win0 tag", 32'(cpf), 32'd5);
    chk("R1 R6 wide win0 addr", ca, 32'h0001_2300);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule